// File: doc/BRIEF.md
# Squashable Instruction Queue with Register Credits

This block holds fetched instructions in program order between fetch and dispatch. Each accepted instruction gets a sequence number from a counter that only counts up. The entry stores that number, the instruction's PC and how many destination registers it will claim. Dispatch takes entries from the head. The read result appears on the pop outputs one cycle after the request.

A recovery request carries a sequence number. It starts a walk from the tail that removes one entry per cycle while the youngest remaining entry is younger than that number. Older entries stay in the queue. Each removed entry returns its destination-register count to a signed pool of free physical registers. The pool is charged when an instruction is queued. It is also refilled through a release port and never rises above the physical register total. When the pool is at zero or below, the block reports rename-blocked and refuses new instructions. Two running statistics are kept: the sum of the occupancy over all cycles, and the number of cycles spent full.

Top module: `squash_iq`

## Requirements
- R1: A push is accepted when `push_valid`, `push_ready` and not `squash_req` are all high in the same cycle. The entry takes the value shown on `push_seq`, and `push_seq` then rises by exactly one.
- R2: `push_ready` is high only when the queue holds fewer than DEPTH entries, `rename_blocked` is low and no squash walk is in progress (`squash_busy` low).
- R3: If `pop_req` is high and the queue is not empty, the head entry is removed, and in the next cycle `pop_valid` is 1 with that entry's sequence number, PC and register count. A pop request on an empty queue gives `pop_valid` 0 and changes nothing.
- R4: After `squash_req` with number S, `squash_busy` is high from the next cycle on. In each busy cycle where the tail entry's number is greater than S, that tail entry is removed. The first busy cycle that finds the queue empty or the tail number not greater than S ends the walk. Entries with numbers up to and including S are kept.
- R5: Pop requests are ignored in the cycle `squash_req` is high and in every busy cycle: `pop_valid` is 0 in the following cycle and the occupancy does not fall because of them.
- R6: A push in the same cycle as `squash_req` is dropped. Neither the occupancy nor `push_seq` advances.
- R7: After reset `free_regs` equals NUM_PREGS. Each accepted push subtracts its register count from it.
- R8: Each entry removed by the squash walk adds its register count back to `free_regs`.
- R9: `release_valid` adds `release_cnt` to `free_regs`. After all charges and credits in a cycle, the value is clamped so it never exceeds NUM_PREGS.
- R10: `free_regs` is two's complement. `rename_blocked` is high exactly when `free_regs` is zero or negative, and it clears in the cycle after the credits bring the sum above zero.
- R11: Each cycle `occ_sum` grows by the occupancy held at the start of that cycle, and `full_cycles` grows by one in each cycle that starts with the queue holding DEPTH entries.
- R12: While `rst` is high the queue is empty: `pop_valid` 0, `squash_busy` 0, `rename_blocked` 0, `push_seq` 0, and both statistics 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Offer an instruction |
| push_pc | input | PC_W | PC of the offered instruction |
| push_ndst | input | NDST_W | Destination registers the instruction claims |
| push_ready | output | 1 | Queue can accept this cycle |
| push_seq | output | SEQ_W | Sequence number the next accepted push receives |
| pop_req | input | 1 | Dispatch requests the head entry |
| pop_valid | output | 1 | Pop data valid (one cycle after request) |
| pop_seq | output | SEQ_W | Sequence number of popped entry |
| pop_pc | output | PC_W | PC of popped entry |
| pop_ndst | output | NDST_W | Register count of popped entry |
| squash_req | input | 1 | Start removing entries younger than `squash_seq` |
| squash_seq | input | SEQ_W | Youngest sequence number to keep |
| squash_busy | output | 1 | Tail walk in progress |
| release_valid | input | 1 | Return registers to the pool |
| release_cnt | input | REL_W | Number of registers returned |
| free_regs | output | clog2(NUM_PREGS+1)+NDST_W+1 | Signed free-register count |
| rename_blocked | output | 1 | Free pool exhausted |
| occupancy | output | clog2(DEPTH+1) | Entries currently queued |
| occ_sum | output | STAT_W | Cumulative occupancy |
| full_cycles | output | STAT_W | Cycles spent full |

## Verification
The stimulus moves through several patterns:
- Plain push and pop, including a pop on an empty queue. These separate head order and the one-cycle read latency from an empty pop that must leave everything unchanged.
- Filling to DEPTH with register count zero. This makes back-pressure depend only on occupancy, and the full-cycle statistic is seen moving.
- Squashes with a number that is in the middle of the queue, above every entry, and below every entry. These separate a partial walk, a walk that ends at once, and a full drain, and each returns a different register credit.
- A push in the squash cycle, pops during the walk, and heavy pushes that drain the pool followed by small releases. These isolate squash priority, the pop lockout, the exhaustion boundary at zero and the clamp.

A long random mix then runs against the behavioural model cycle by cycle.

// File: rtl/iq_pkg.sv
`timescale 1ns/1ps
package iq_pkg;
  typedef enum logic {
    WALK_IDLE   = 1'b0,
    WALK_ACTIVE = 1'b1
  } walk_e;

  function automatic int clamp_high(input int v, input int top);
    return (v > top) ? top : v;
  endfunction
endpackage

// File: rtl/iq_store.sv
`timescale 1ns/1ps
module iq_store #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int PC_W   = 32,
  parameter int NDST_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push,
  input  logic [SEQ_W-1:0]            push_seq,
  input  logic [PC_W-1:0]             push_pc,
  input  logic [NDST_W-1:0]           push_ndst,
  input  logic                        pop,
  input  logic                        drop_tail,
  output logic                        out_valid,
  output logic [SEQ_W-1:0]            out_seq,
  output logic [PC_W-1:0]             out_pc,
  output logic [NDST_W-1:0]           out_ndst,
  output logic [SEQ_W-1:0]            tail_seq,
  output logic [NDST_W-1:0]           tail_ndst,
  output logic [$clog2(DEPTH+1)-1:0]  count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [SEQ_W-1:0]  mem_seq [DEPTH];
  logic [PC_W-1:0]   mem_pc  [DEPTH];
  logic [NDST_W-1:0] mem_nd  [DEPTH];

  logic [PTR_W-1:0] wr_ptr, rd_ptr, tail_idx;
  logic [CNT_W-1:0] count_nxt;

  assign tail_idx  = (wr_ptr == '0) ? PTR_W'(DEPTH-1) : wr_ptr - 1'b1;
  assign tail_seq  = mem_seq[tail_idx];
  assign tail_ndst = mem_nd[tail_idx];
  assign count_nxt = count + CNT_W'(push) - CNT_W'(pop) - CNT_W'(drop_tail);

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) begin
      mem_seq[wr_ptr] <= push_seq;
      mem_pc[wr_ptr]  <= push_pc;
      mem_nd[wr_ptr]  <= push_ndst;
    end
    if (pop) begin
      out_seq  <= mem_seq[rd_ptr];
      out_pc   <= mem_pc[rd_ptr];
      out_ndst <= mem_nd[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= pop;
      count     <= count_nxt;
      if (push)
        wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      else if (drop_tail)
        wr_ptr <= tail_idx;
      if (pop)
        rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CNT_W'(DEPTH)));
  // R3
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
  // R4
  drop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    drop_tail |-> (count != '0) && !pop && !push);
endmodule

// File: rtl/iq_credit.sv
`timescale 1ns/1ps
module iq_credit #(
  parameter int NUM_PREGS = 16,
  parameter int NDST_W    = 2,
  parameter int REL_W     = 4,
  parameter int FREE_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     debit,
  input  logic [NDST_W-1:0]        debit_cnt,
  input  logic                     sq_credit,
  input  logic [NDST_W-1:0]        sq_cnt,
  input  logic                     rel_valid,
  input  logic [REL_W-1:0]         rel_cnt,
  output logic signed [FREE_W-1:0] free_regs,
  output logic                     blocked
);
  import iq_pkg::*;

  int nxt;

  always_comb begin
    nxt = int'(free_regs);
    if (debit)     nxt = nxt - int'(debit_cnt);
    if (sq_credit) nxt = nxt + int'(sq_cnt);
    if (rel_valid) nxt = nxt + int'(rel_cnt);
    nxt = clamp_high(nxt, NUM_PREGS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_regs <= FREE_W'(NUM_PREGS);
      blocked   <= 1'b0;
    end else begin
      free_regs <= FREE_W'(nxt);
      blocked   <= (nxt <= 0);
    end
  end

  // R9
  free_cap_chk: assert property (@(posedge clk) disable iff (rst)
    int'(free_regs) <= NUM_PREGS);
  // R10
  unblock_chk: assert property (@(posedge clk) disable iff (rst)
    (blocked && !debit && rel_valid && (int'(free_regs) + int'(rel_cnt) > 0)) |=> !blocked);
endmodule

// File: rtl/iq_stats.sv
`timescale 1ns/1ps
module iq_stats #(
  parameter int DEPTH  = 8,
  parameter int STAT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  output logic [STAT_W-1:0]          occ_sum,
  output logic [STAT_W-1:0]          full_cycles
);
  localparam int CNT_W = $clog2(DEPTH+1);

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_sum     <= '0;
      full_cycles <= '0;
    end else begin
      occ_sum     <= occ_sum + STAT_W'(count);
      full_cycles <= full_cycles + STAT_W'(count == CNT_W'(DEPTH));
    end
  end

  // R11
  occ_accum_chk: assert property (@(posedge clk) disable iff (rst)
    occ_sum == $past(occ_sum) + STAT_W'($past(count)));
endmodule

// File: rtl/squash_iq.sv
`timescale 1ns/1ps
module squash_iq #(
  parameter int DEPTH     = 8,
  parameter int SEQ_W     = 16,
  parameter int PC_W      = 32,
  parameter int NDST_W    = 2,
  parameter int NUM_PREGS = 16,
  parameter int REL_W     = 4,
  parameter int STAT_W    = 32
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          push_valid,
  input  logic [PC_W-1:0]                               push_pc,
  input  logic [NDST_W-1:0]                             push_ndst,
  output logic                                          push_ready,
  output logic [SEQ_W-1:0]                              push_seq,
  input  logic                                          pop_req,
  output logic                                          pop_valid,
  output logic [SEQ_W-1:0]                              pop_seq,
  output logic [PC_W-1:0]                               pop_pc,
  output logic [NDST_W-1:0]                             pop_ndst,
  input  logic                                          squash_req,
  input  logic [SEQ_W-1:0]                              squash_seq,
  output logic                                          squash_busy,
  input  logic                                          release_valid,
  input  logic [REL_W-1:0]                              release_cnt,
  output logic signed [$clog2(NUM_PREGS+1)+NDST_W:0]    free_regs,
  output logic                                          rename_blocked,
  output logic [$clog2(DEPTH+1)-1:0]                    occupancy,
  output logic [STAT_W-1:0]                             occ_sum,
  output logic [STAT_W-1:0]                             full_cycles
);
  import iq_pkg::*;

  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int FREE_W = $clog2(NUM_PREGS+1) + NDST_W + 1;

  walk_e             walk_q;
  logic [SEQ_W-1:0]  keep_seq_q;
  logic [SEQ_W-1:0]  tail_seq;
  logic [NDST_W-1:0] tail_ndst;
  logic              accept, pop_do, walk_rm;

  assign squash_busy = (walk_q == WALK_ACTIVE);
  assign push_ready  = (occupancy != CNT_W'(DEPTH)) && !rename_blocked && !squash_busy;
  assign accept      = push_valid && push_ready && !squash_req;
  assign pop_do      = pop_req && (occupancy != '0) && !squash_busy && !squash_req;
  assign walk_rm     = squash_busy && (occupancy != '0) && (tail_seq > keep_seq_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      walk_q     <= WALK_IDLE;
      keep_seq_q <= '0;
      push_seq   <= '0;
    end else begin
      if (accept) push_seq <= push_seq + 1'b1;
      if (squash_req) begin
        walk_q     <= WALK_ACTIVE;
        keep_seq_q <= squash_seq;
      end else if (squash_busy && !walk_rm) begin
        walk_q <= WALK_IDLE;
      end
    end
  end

  iq_store #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W), .NDST_W(NDST_W)) u_store (
    .clk(clk), .rst(rst),
    .push(accept), .push_seq(push_seq), .push_pc(push_pc), .push_ndst(push_ndst),
    .pop(pop_do), .drop_tail(walk_rm),
    .out_valid(pop_valid), .out_seq(pop_seq), .out_pc(pop_pc), .out_ndst(pop_ndst),
    .tail_seq(tail_seq), .tail_ndst(tail_ndst), .count(occupancy)
  );

  iq_credit #(.NUM_PREGS(NUM_PREGS), .NDST_W(NDST_W), .REL_W(REL_W), .FREE_W(FREE_W)) u_credit (
    .clk(clk), .rst(rst),
    .debit(accept), .debit_cnt(push_ndst),
    .sq_credit(walk_rm), .sq_cnt(tail_ndst),
    .rel_valid(release_valid), .rel_cnt(release_cnt),
    .free_regs(free_regs), .blocked(rename_blocked)
  );

  iq_stats #(.DEPTH(DEPTH), .STAT_W(STAT_W)) u_stats (
    .clk(clk), .rst(rst), .count(occupancy),
    .occ_sum(occ_sum), .full_cycles(full_cycles)
  );

  // R4
  walk_step_chk: assert property (@(posedge clk) disable iff (rst)
    walk_rm |=> (occupancy == $past(occupancy) - 1'b1));
  // R5
  pop_lockout_chk: assert property (@(posedge clk) disable iff (rst)
    (squash_req || squash_busy) |=> !pop_valid);
  // R6
  squash_wins_chk: assert property (@(posedge clk) disable iff (rst)
    squash_req |=> (push_seq == $past(push_seq)) && (occupancy <= $past(occupancy)));
  // R1
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (push_valid && push_ready && !squash_req) |=> (push_seq == $past(push_seq) + 1'b1));
endmodule

// File: tb/tb_squash_iq.sv
`timescale 1ns/1ps
module tb_squash_iq;
  localparam int DEPTH = 8;
  localparam int NPR   = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 0, pop_req = 0, squash_req = 0, release_valid = 0;
  logic [31:0] push_pc = '0;
  logic [1:0]  push_ndst = '0;
  logic [15:0] squash_seq = '0;
  logic [3:0]  release_cnt = '0;
  logic        push_ready, pop_valid, squash_busy, rename_blocked;
  logic [15:0] push_seq, pop_seq;
  logic [31:0] pop_pc, occ_sum, full_cycles;
  logic [1:0]  pop_ndst;
  logic signed [7:0] free_regs;
  logic [3:0]  occupancy;

  always #2.5 clk = ~clk;

  squash_iq dut (
    .clk(clk), .rst(rst),
    .push_valid(push_valid), .push_pc(push_pc), .push_ndst(push_ndst),
    .push_ready(push_ready), .push_seq(push_seq),
    .pop_req(pop_req), .pop_valid(pop_valid), .pop_seq(pop_seq),
    .pop_pc(pop_pc), .pop_ndst(pop_ndst),
    .squash_req(squash_req), .squash_seq(squash_seq), .squash_busy(squash_busy),
    .release_valid(release_valid), .release_cnt(release_cnt),
    .free_regs(free_regs), .rename_blocked(rename_blocked),
    .occupancy(occupancy), .occ_sum(occ_sum), .full_cycles(full_cycles)
  );

  typedef struct {
    bit [15:0] seq;
    bit [31:0] pc;
    bit [1:0]  nd;
  } ent_t;

  ent_t      mq[$];
  int        m_free, m_seq, m_keep;
  bit        m_blk, m_walk, m_pv;
  ent_t      m_pop;
  longint    m_occ, m_full;
  int        n_chk = 0, n_fail = 0;
  bit        cmp_en = 0;
  bit        finished = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin : model
    int  cnt;
    bit  rdy, acc, pdo, wrm;
    int  nxt;
    if (rst) begin
      mq.delete();
      m_free = NPR; m_seq = 0; m_keep = 0;
      m_blk = 0; m_walk = 0; m_pv = 0; m_occ = 0; m_full = 0;
    end else begin
      cnt = mq.size();
      rdy = (cnt < DEPTH) && !m_blk && !m_walk;
      acc = push_valid && rdy && !squash_req;
      pdo = pop_req && (cnt > 0) && !m_walk && !squash_req;
      wrm = m_walk && (cnt > 0) && (mq[cnt-1].seq > m_keep[15:0]);
      m_occ  = (m_occ + cnt) & 64'hFFFF_FFFF;
      m_full = (m_full + ((cnt == DEPTH) ? 1 : 0)) & 64'hFFFF_FFFF;
      nxt = m_free;
      if (acc) nxt -= push_ndst;
      if (wrm) nxt += mq[cnt-1].nd;
      if (release_valid) nxt += release_cnt;
      if (nxt > NPR) nxt = NPR;
      m_free = nxt;
      m_blk  = (nxt <= 0);
      m_pv = pdo;
      if (pdo) m_pop = mq.pop_front();
      if (wrm) void'(mq.pop_back());
      if (acc) begin
        ent_t e;
        e.seq = m_seq[15:0]; e.pc = push_pc; e.nd = push_ndst;
        mq.push_back(e);
        m_seq++;
      end
      if (squash_req) begin
        m_walk = 1; m_keep = squash_seq;
      end else if (m_walk && !wrm) begin
        m_walk = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk("R1 push_seq", push_seq, m_seq & 16'hFFFF);
      chk("R2 push_ready", push_ready, (mq.size() < DEPTH) && !m_blk && !m_walk);
      chk("R3 pop_valid", pop_valid, m_pv);
      if (m_pv) begin
        chk("R3 pop_seq", pop_seq, m_pop.seq);
        chk("R3 pop_pc", pop_pc, m_pop.pc);
        chk("R3 pop_ndst", pop_ndst, m_pop.nd);
      end
      chk("R4 occupancy", occupancy, mq.size());
      chk("R4 squash_busy", squash_busy, m_walk);
      chk("R7 free_regs", free_regs, m_free);
      chk("R10 rename_blocked", rename_blocked, m_blk);
      chk("R11 occ_sum", occ_sum, m_occ);
      chk("R11 full_cycles", full_cycles, m_full);
    end
  end

  task automatic step(input bit pv, input int pc, input int nd, input bit pr,
                      input bit sq, input int sqs, input bit rv, input int rc);
    push_valid = pv; push_pc = pc; push_ndst = nd[1:0]; pop_req = pr;
    squash_req = sq; squash_seq = sqs[15:0]; release_valid = rv; release_cnt = rc[3:0];
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int s0, s1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 pop_valid", pop_valid, 0);
    chk("R12 squash_busy", squash_busy, 0);
    chk("R12 rename_blocked", rename_blocked, 0);
    chk("R12 push_seq", push_seq, 0);
    chk("R12 occ_sum", occ_sum, 0);
    chk("R12 free_regs", free_regs, NPR);
    rst = 0; cmp_en = 1;

    // plain push / pop, and a pop on empty (R3)
    step(1, 32'h100, 1, 0, 0, 0, 0, 0);
    step(1, 32'h104, 2, 0, 0, 0, 0, 0);
    step(1, 32'h108, 3, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R3 empty pop", pop_valid, 0);
    step(0, 0, 0, 0, 0, 0, 1, 15);

    // fill to DEPTH with zero register counts (R2, R11)
    for (int i = 0; i < DEPTH + 2; i++) step(1, 32'h200 + 4*i, 0, 0, 0, 0, 0, 0);
    chk("R2 full ready", push_ready, 0);
    chk("R11 full count", full_cycles, m_full);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, 0, 0, 0);
    idle(1);

    // partial squash with credit return (R4, R8)
    s0 = m_seq;
    for (int i = 0; i < 4; i++) step(1, 32'h300 + 4*i, 2, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, s0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 pop during walk", pop_valid, 0);
    idle(4);
    chk("R4 kept oldest", occupancy, 1);
    chk("R8 credit back", free_regs, NPR - 2);
    // squash above all entries: no removal
    step(0, 0, 0, 0, 1, m_seq + 5, 0, 0);
    idle(2);
    chk("R4 nothing removed", occupancy, 1);
    // squash below all: drain
    step(0, 0, 0, 0, 1, 0, 0, 0);
    idle(3);
    chk("R4 drained", occupancy, 0);
    chk("R8 full credit", free_regs, NPR);

    // squash and push in same cycle (R6)
    s1 = m_seq;
    step(1, 32'h400, 1, 0, 1, s1 + 3, 0, 0);
    chk("R6 seq not consumed", push_seq, s1 & 16'hFFFF);
    chk("R6 push dropped", occupancy, 0);
    idle(2);

    // exhaustion and recovery (R10, R9)
    for (int i = 0; i < 6; i++) step(1, 32'h500 + 4*i, 3, 0, 0, 0, 0, 0);
    chk("R10 blocked", rename_blocked, 1);
    chk("R10 negative pool", free_regs, -2);
    step(0, 0, 0, 0, 0, 0, 1, 2);
    chk("R10 still blocked at zero", rename_blocked, 1);
    step(0, 0, 0, 0, 0, 0, 1, 3);
    chk("R10 unblocked", rename_blocked, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 15);
    step(0, 0, 0, 0, 0, 0, 1, 15);
    chk("R9 clamp", free_regs, NPR);
    idle(2);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      bit sq;
      int sqs;
      sq  = ($urandom % 100) < 4;
      sqs = (m_seq > 0) ? m_seq - 1 - int'($urandom % 6) : 0;
      if (sqs < 0) sqs = 0;
      step(($urandom % 100) < 60, $urandom, $urandom % 4, ($urandom % 100) < 40,
           sq, sqs, ($urandom % 100) < 25, $urandom % 16);
    end
    idle(10);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule